// File: doc/BRIEF.md
# Transactional Line Cache with Dual Images

This block is a small, fully associative cache that tracks every word-sized line a transaction touches, whether the line is only read or also written. Each entry holds two images of its line: the committed value from before the transaction and the value with the transaction's stores applied. A per-entry selector bit marks which physical copy is the committed one. Commit and abort therefore finish in one cycle by changing entry states and selector bits. No data is copied.

A transaction starts with its first transactional load or store and ends with a commit or abort request. The block answers snooped reads and writes from other agents in the same cycle with exactly one of ACK or NACK. A NACK tells the remote agent that its own transaction must abort; the local transaction is not stalled. The local transaction is marked aborted when one of its own fills is refused, or when it runs out of entries. Software can poll this with a validate request. Restarting after an abort is left to software. Misses use a simple fill handshake. A committed line that is displaced goes through a writeback handshake first.

Top module: `txline_cache`

## Requirements
- R1: After reset every entry is empty, `tx_aborted`, `tx_overflow`, `cpu_done`, `fill_req` and `wb_req` are 0, `cpu_ready` is 1, and a validate returns `cpu_ok`=1.
- R2: A load that misses raises `fill_req` with the load address. When `fill_ack` arrives, both images are loaded with `fill_data` and that value is returned. A later load of the same address hits without a fill and returns the same value.
- R3: A store places its data in the after-image only. A load in the same transaction then returns the stored value, and a store hit causes no fill.
- R4: When `snp_valid` is 1, exactly one of `snp_ack`/`snp_nack` is high in that same cycle. NACK is given for a remote write to any transactional line, or a remote read of a line the transaction wrote. Remote reads of lines that were only read are ACKed, and so are snoops that miss. A NACK does not change `tx_aborted`.
- R5: A commit (`cpu_ok`=1 when not aborted) makes every after-image the committed value and leaves every touched line non-transactional. Later loads return the stored values and snoops to those lines are ACKed.
- R6: An abort discards all after-images. Later loads return the before-image values, and `tx_aborted` and `tx_overflow` are cleared.
- R7: Opcodes are 0 load, 1 store, 2 validate, 3 commit, 4 abort. A validate returns `cpu_ok`=0 when an abort is pending and 1 otherwise. Unused opcodes complete with `cpu_ok`=0 and change nothing.
- R8: `fill_nack` during a fill sets `tx_aborted` and completes the access with `cpu_ok`=0. A commit issued while aborted acts as an abort and returns `cpu_ok`=0.
- R9: A miss when every entry is transactional issues no fill. It sets `tx_aborted` and `tx_overflow` and completes with `cpu_ok`=0.
- R10: A miss allocates the lowest-indexed empty entry. If no entry is empty, it takes the lowest-indexed committed (non-transactional) entry, which is first written back on `wb_addr`/`wb_data` until `wb_ack`.
- R11: A remote write to a committed, non-transactional line is ACKed and drops that line, so the next access to it misses.
- R12: A snoop that arrives in the same cycle as an accepted load or store to the same line is judged as if the access had already happened. A snoop that arrives in the same cycle as a commit is judged against the state before the commit.
- R13: A request accepted while `cpu_ready` is 1 that hits, or that needs no line, raises `cpu_done` for one cycle at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request strobe, taken when `cpu_ready` is 1 |
| cpu_op | input | 3 | 0 load, 1 store, 2 validate, 3 commit, 4 abort |
| cpu_addr | input | AW | Word address of a load or store |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Load result (line value before a store for a store miss) |
| cpu_ok | output | 1 | Success of the completed request |
| tx_aborted | output | 1 | Abort pending for the current transaction |
| tx_overflow | output | 1 | Abort was caused by lack of entries |
| snp_valid | input | 1 | Remote request present |
| snp_write | input | 1 | Remote request is a write |
| snp_addr | input | AW | Remote request address |
| snp_ack | output | 1 | Remote request accepted |
| snp_nack | output | 1 | Remote request refused (conflict) |
| fill_req | output | 1 | Line fill request |
| fill_addr | output | AW | Address to fill |
| fill_ack | input | 1 | Fill data valid |
| fill_nack | input | 1 | Fill refused by the system |
| fill_data | input | DW | Fill data |
| wb_req | output | 1 | Writeback request for a displaced committed line |
| wb_addr | output | AW | Writeback address |
| wb_data | output | DW | Writeback data |
| wb_ack | input | 1 | Writeback accepted |

## Verification
The delicate case is a snoop that lands in the same cycle as a processor operation. This can be a load or store to the same line, or a commit that flips the line out of the transactional state. The bench drives the snoop and the request on the same clock low phase. It samples the snoop answer before the next edge. It expects NACK when the access would make the line conflict, and NACK for a snoop that meets a commit on a written line. It then checks with a lone snoop that the committed line is ACKed one cycle later, and that the commit itself reported success.

// File: rtl/txline_cache.sv
module txline_cache #(
  parameter int ENTRIES = 8,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic [2:0]    cpu_op,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ok,
  output logic          tx_aborted,
  output logic          tx_overflow,
  input  logic          snp_valid,
  input  logic          snp_write,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_ack,
  output logic          snp_nack,
  output logic          fill_req,
  output logic [AW-1:0] fill_addr,
  input  logic          fill_ack,
  input  logic          fill_nack,
  input  logic [DW-1:0] fill_data,
  output logic          wb_req,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  input  logic          wb_ack
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [1:0] S_INV = 2'd0, S_CLN = 2'd1, S_TRD = 2'd2, S_TWR = 2'd3;
  localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_VAL = 3'd2, OP_CM = 3'd3, OP_AB = 3'd4;

  typedef enum logic [1:0] {F_IDLE, F_WB, F_FILL} fsm_t;

  logic [1:0]    st   [ENTRIES];
  logic [AW-1:0] tag  [ENTRIES];
  logic [DW-1:0] img0 [ENTRIES];
  logic [DW-1:0] img1 [ENTRIES];
  logic [ENTRIES-1:0] sel;

  fsm_t          fsm;
  logic [IW-1:0] vic;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_wdata;
  logic          pend_st;

  logic          cpu_hit, snp_hit, free_ok, cln_ok, any_tx;
  logic [IW-1:0] cpu_hidx, snp_hidx, free_idx, cln_idx;

  always_comb begin
    cpu_hit = 1'b0; cpu_hidx = '0;
    snp_hit = 1'b0; snp_hidx = '0;
    free_ok = 1'b0; free_idx = '0;
    cln_ok  = 1'b0; cln_idx  = '0;
    any_tx  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (st[i] != S_INV && tag[i] == cpu_addr) begin cpu_hit = 1'b1; cpu_hidx = IW'(i); end
      if (st[i] != S_INV && tag[i] == snp_addr) begin snp_hit = 1'b1; snp_hidx = IW'(i); end
      if (st[i] == S_INV) begin free_ok = 1'b1; free_idx = IW'(i); end
      if (st[i] == S_CLN) begin cln_ok = 1'b1; cln_idx = IW'(i); end
      if (st[i][1]) any_tx = 1'b1;
    end
  end

  assign cpu_ready = (fsm == F_IDLE);
  wire accept = cpu_req && cpu_ready;
  wire is_acc = accept && (cpu_op == OP_LD || cpu_op == OP_ST);
  wire touch  = is_acc && cpu_hit && snp_hit && (cpu_hidx == snp_hidx);
  wire [1:0] sst = st[snp_hidx];
  wire conflict = snp_hit && (sst == S_TWR || (snp_write && sst == S_TRD) ||
                              (touch && (snp_write || cpu_op == OP_ST)));

  assign snp_nack = snp_valid && conflict;
  assign snp_ack  = snp_valid && !conflict;

  wire [DW-1:0] hit_before = sel[cpu_hidx] ? img1[cpu_hidx] : img0[cpu_hidx];
  wire [DW-1:0] hit_after  = sel[cpu_hidx] ? img0[cpu_hidx] : img1[cpu_hidx];

  assign fill_req  = (fsm == F_FILL);
  assign fill_addr = pend_addr;
  assign wb_req    = (fsm == F_WB);
  assign wb_addr   = tag[vic];
  assign wb_data   = sel[vic] ? img1[vic] : img0[vic];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        st[i] <= S_INV; tag[i] <= '0; img0[i] <= '0; img1[i] <= '0;
      end
      sel <= '0; fsm <= F_IDLE; vic <= '0;
      pend_addr <= '0; pend_wdata <= '0; pend_st <= 1'b0;
      cpu_done <= 1'b0; cpu_rdata <= '0; cpu_ok <= 1'b0;
      tx_aborted <= 1'b0; tx_overflow <= 1'b0;
    end else begin
      cpu_done <= 1'b0;
      if (snp_valid && snp_write && snp_hit && !conflict && sst == S_CLN)
        st[snp_hidx] <= S_INV;
      case (fsm)
        F_IDLE: if (accept) begin
          cpu_done <= 1'b1;
          cpu_ok   <= 1'b1;
          case (cpu_op)
            OP_LD, OP_ST: begin
              if (cpu_hit) begin
                if (cpu_op == OP_ST) begin
                  if (sel[cpu_hidx]) img0[cpu_hidx] <= cpu_wdata;
                  else               img1[cpu_hidx] <= cpu_wdata;
                  st[cpu_hidx] <= S_TWR;
                  cpu_rdata <= hit_after;
                end else begin
                  cpu_rdata <= (st[cpu_hidx] == S_TWR) ? hit_after : hit_before;
                  if (st[cpu_hidx] == S_CLN) st[cpu_hidx] <= S_TRD;
                end
              end else if (free_ok || cln_ok) begin
                cpu_done   <= 1'b0;
                pend_addr  <= cpu_addr;
                pend_wdata <= cpu_wdata;
                pend_st    <= (cpu_op == OP_ST);
                vic <= free_ok ? free_idx : cln_idx;
                fsm <= free_ok ? F_FILL : F_WB;
              end else begin
                tx_aborted  <= 1'b1;
                tx_overflow <= 1'b1;
                cpu_ok      <= 1'b0;
                cpu_rdata   <= '0;
              end
            end
            OP_VAL: cpu_ok <= !tx_aborted;
            OP_CM, OP_AB: begin
              for (int i = 0; i < ENTRIES; i++) begin
                if (cpu_op == OP_CM && !tx_aborted && st[i] == S_TWR) sel[i] <= ~sel[i];
                if (st[i][1]) st[i] <= S_CLN;
              end
              if (cpu_op == OP_CM) cpu_ok <= !tx_aborted;
              tx_aborted  <= 1'b0;
              tx_overflow <= 1'b0;
            end
            default: cpu_ok <= 1'b0;
          endcase
        end
        F_WB: if (wb_ack) begin
          st[vic] <= S_INV;
          fsm <= F_FILL;
        end
        F_FILL: if (fill_ack) begin
          tag[vic]  <= pend_addr;
          img0[vic] <= fill_data;
          img1[vic] <= pend_st ? pend_wdata : fill_data;
          sel[vic]  <= 1'b0;
          st[vic]   <= pend_st ? S_TWR : S_TRD;
          cpu_done  <= 1'b1; cpu_ok <= 1'b1; cpu_rdata <= fill_data;
          fsm <= F_IDLE;
        end else if (fill_nack) begin
          tx_aborted <= 1'b1;
          cpu_done <= 1'b1; cpu_ok <= 1'b0; cpu_rdata <= '0;
          fsm <= F_IDLE;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  // R4
  quiet_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !any_tx && !is_acc) |-> snp_ack);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_overflow) |-> tx_aborted);
  // R8
  fill_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_FILL && fill_nack && !fill_ack) |=> tx_aborted);
  // R5
  end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cpu_op == OP_CM || cpu_op == OP_AB)) |=> !any_tx);
  // R10
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_ack) |=> fill_req);
  // R13
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> ($past(accept) || $past(fsm == F_FILL)));
endmodule

// File: tb/txline_cache_tb.sv
module txline_cache_tb_top;
  localparam int AW = 32, DW = 32;
  localparam logic [2:0] LD = 3'd0, ST = 3'd1, VA = 3'd2, CM = 3'd3, AB = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cpu_req = 0; logic [2:0] cpu_op = 0; logic [AW-1:0] cpu_addr = 0; logic [DW-1:0] cpu_wdata = 0;
  logic cpu_ready, cpu_done, cpu_ok, tx_aborted, tx_overflow;
  logic [DW-1:0] cpu_rdata;
  logic snp_valid = 0, snp_write = 0; logic [AW-1:0] snp_addr = 0;
  logic snp_ack, snp_nack;
  logic fill_req, fill_ack = 0, fill_nack = 0; logic [AW-1:0] fill_addr; logic [DW-1:0] fill_data = 0;
  logic wb_req, wb_ack = 0; logic [AW-1:0] wb_addr; logic [DW-1:0] wb_data;

  txline_cache dut_i (.*);

  int checks = 0, fails = 0, fills = 0, wbs = 0, lat = 0;
  logic nack_mode = 0;
  logic [DW-1:0] r_data, last_wb_data; logic [AW-1:0] last_wb_addr; logic r_ok, r_snack;

  function automatic logic [DW-1:0] fd(input logic [AW-1:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op_snp(input logic [2:0] o, input logic [AW-1:0] a, input logic [DW-1:0] w,
                        input logic sv, input logic sw, input logic [AW-1:0] sa);
    int guard = 0;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1; cpu_op = o; cpu_addr = a; cpu_wdata = w;
    snp_valid = sv; snp_write = sw; snp_addr = sa;
    #1 r_snack = snp_nack;
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      cpu_req = 0; snp_valid = 0; fill_ack = 0; fill_nack = 0; wb_ack = 0;
      if (cpu_done) begin r_data = cpu_rdata; r_ok = cpu_ok; break; end
      if (wb_req) begin wbs++; last_wb_addr = wb_addr; last_wb_data = wb_data; wb_ack = 1; end
      else if (fill_req) begin
        if (nack_mode) fill_nack = 1;
        else begin fills++; fill_data = fd(fill_addr); fill_ack = 1; end
      end
      guard++;
      if (guard > 50) begin fails++; $display("FAIL R13 op hung actual=%0d expected=<50", guard); break; end
    end
  endtask

  task automatic op(input logic [2:0] o, input logic [AW-1:0] a, input logic [DW-1:0] w);
    op_snp(o, a, w, 1'b0, 1'b0, '0);
  endtask

  task automatic snoop(input logic w, input logic [AW-1:0] a, input logic exp_nack, input string tag);
    @(negedge clk);
    snp_valid = 1; snp_write = w; snp_addr = a;
    #1;
    chk({tag, " ack/nack"}, {30'd0, snp_ack, snp_nack}, {30'd0, !exp_nack, exp_nack});
    @(negedge clk);
    snp_valid = 0;
  endtask

  typedef struct packed {
    logic [2:0]  o;
    logic [31:0] a;
    logic [31:0] w;
    logic [31:0] rd;
    logic        ok;
    logic        fl;
    logic        crd;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{VA, 32'h0,   32'h0,        32'h0,          1'b1, 1'b0, 1'b0, 4'd1},  // R1
    '{LD, 32'h100, 32'h0,        32'h100^32'hC0DE_0000, 1'b1, 1'b1, 1'b1, 4'd2},  // R2 miss
    '{LD, 32'h100, 32'h0,        32'h100^32'hC0DE_0000, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 hit
    '{ST, 32'h100, 32'h11111111, 32'h0,          1'b1, 1'b0, 1'b0, 4'd3},  // R3
    '{LD, 32'h100, 32'h0,        32'h11111111,   1'b1, 1'b0, 1'b1, 4'd3},  // R3
    '{ST, 32'h104, 32'h22222222, 32'h0,          1'b1, 1'b1, 1'b0, 4'd3},  // R3 store miss
    '{LD, 32'h104, 32'h0,        32'h22222222,   1'b1, 1'b0, 1'b1, 4'd3},  // R3
    '{CM, 32'h0,   32'h0,        32'h0,          1'b1, 1'b0, 1'b0, 4'd5},  // R5
    '{LD, 32'h100, 32'h0,        32'h11111111,   1'b1, 1'b0, 1'b1, 4'd5},  // R5
    '{ST, 32'h100, 32'h33333333, 32'h0,          1'b1, 1'b0, 1'b0, 4'd3},  // R3
    '{LD, 32'h100, 32'h0,        32'h33333333,   1'b1, 1'b0, 1'b1, 4'd3},  // R3
    '{AB, 32'h0,   32'h0,        32'h0,          1'b1, 1'b0, 1'b0, 4'd6},  // R6
    '{LD, 32'h100, 32'h0,        32'h11111111,   1'b1, 1'b0, 1'b1, 4'd6},  // R6
    '{LD, 32'h104, 32'h0,        32'h22222222,   1'b1, 1'b0, 1'b1, 4'd5},  // R5
    '{CM, 32'h0,   32'h0,        32'h0,          1'b1, 1'b0, 1'b0, 4'd5}   // R5
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {26'd0, cpu_ready, cpu_done, tx_aborted, tx_overflow, fill_req, wb_req},
        {26'd0, 1'b1, 5'b0});
    snoop(1'b1, 32'h100, 1'b0, "R1 empty snoop");

    foreach (VECS[k]) begin
      automatic int f0 = fills;
      op(VECS[k].o, VECS[k].a, VECS[k].w);
      chk($sformatf("R%0d vec%0d ok", VECS[k].req, k), {31'd0, r_ok}, {31'd0, VECS[k].ok});
      if (VECS[k].crd) chk($sformatf("R%0d vec%0d rdata", VECS[k].req, k), r_data, VECS[k].rd);
      chk($sformatf("R%0d vec%0d fill", VECS[k].req, k), 32'(fills - f0), {31'd0, VECS[k].fl});
    end

    // R13 hit latency
    op(LD, 32'h100, 0);
    chk("R13 hit latency", 32'(lat), 32'd1);

    // R4 snoop rules
    op(ST, 32'h104, 32'h22222222);
    snoop(1'b0, 32'h100, 1'b0, "R4 read of read line");
    snoop(1'b1, 32'h100, 1'b1, "R4 write of read line");
    snoop(1'b0, 32'h104, 1'b1, "R4 read of written line");
    snoop(1'b1, 32'h200, 1'b0, "R4 miss");
    chk("R4 nack leaves abort flag", {31'd0, tx_aborted}, 32'd0);
    op(AB, 0, 0);
    chk("R6 abort ok", {31'd0, r_ok}, 32'd1);

    // R11 remote write drops committed line
    snoop(1'b1, 32'h100, 1'b0, "R11 write of clean line");
    begin
      automatic int f0 = fills;
      op(LD, 32'h100, 0);
      chk("R11 refill", 32'(fills - f0), 32'd1);
      chk("R11 data", r_data, fd(32'h100));
    end
    op(AB, 0, 0);

    // R12 same-cycle snoop and access
    op_snp(LD, 32'h100, 0, 1'b1, 1'b1, 32'h100);
    chk("R12 write vs same-cycle load", {31'd0, r_snack}, 32'd1);
    op_snp(ST, 32'h104, 32'h44444444, 1'b1, 1'b0, 32'h104);
    chk("R12 read vs same-cycle store", {31'd0, r_snack}, 32'd1);
    op_snp(CM, 0, 0, 1'b1, 1'b0, 32'h104);
    chk("R12 read vs same-cycle commit", {31'd0, r_snack}, 32'd1);
    chk("R12 commit ok", {31'd0, r_ok}, 32'd1);
    snoop(1'b0, 32'h104, 1'b0, "R5 committed line acked");
    op(LD, 32'h104, 0);
    chk("R5 committed value", r_data, 32'h44444444);

    // R8 / R7 refused fill
    op(ST, 32'h100, 32'h55555555);
    nack_mode = 1;
    op(LD, 32'h300, 0);
    nack_mode = 0;
    chk("R8 nacked fill ok", {31'd0, r_ok}, 32'd0);
    chk("R8 aborted flag", {31'd0, tx_aborted}, 32'd1);
    op(VA, 0, 0);
    chk("R7 validate pending", {31'd0, r_ok}, 32'd0);
    op(CM, 0, 0);
    chk("R8 commit while aborted", {31'd0, r_ok}, 32'd0);
    op(VA, 0, 0);
    chk("R7 validate clear", {31'd0, r_ok}, 32'd1);
    op(LD, 32'h100, 0);
    chk("R8 store discarded", r_data, fd(32'h100));
    op(3'd7, 0, 0);
    chk("R7 unused opcode", {31'd0, r_ok}, 32'd0);
    op(AB, 0, 0);

    // R10 allocation order and writeback, R9 overflow
    for (int j = 0; j < 6; j++) op(LD, 32'h400 + 32'(4 * j), 0);
    chk("R10 free slots first", 32'(wbs), 32'd0);
    op(LD, 32'h418, 0);
    chk("R10 wb count", 32'(wbs), 32'd1);
    chk("R10 wb addr", last_wb_addr, 32'h100);
    chk("R10 wb data", last_wb_data, fd(32'h100));
    op(LD, 32'h41C, 0);
    chk("R10 second wb addr", last_wb_addr, 32'h104);
    chk("R10 second wb data", last_wb_data, 32'h44444444);
    begin
      automatic int f0 = fills;
      op(LD, 32'h420, 0);
      chk("R9 no fill", 32'(fills - f0), 32'd0);
      chk("R9 ok", {31'd0, r_ok}, 32'd0);
      chk("R9 flags", {30'd0, tx_aborted, tx_overflow}, 32'd3);
    end
    op(AB, 0, 0);
    chk("R6 flags cleared", {30'd0, tx_aborted, tx_overflow}, 32'd0);
    op(LD, 32'h418, 0);
    chk("R6 line kept after abort", r_data, fd(32'h418));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule